// File: doc/BRIEF.md
# Tick-Stream Source Selector with Cascaded Divider

This block picks one of four incoming tick streams and thins it by up to two integer ratios in series, producing a single output tick stream. All logic runs on one system clock. Each source is a one-cycle enable strobe, and the output is a one-cycle tick that downstream logic can use as a clock enable. A 5-bit pre-divider is in the chain only when source 3 is chosen. Every other source feeds the 2-bit post-divider directly.

Settings live in a 32-bit control word that can be read back. Two write ports share one data bus. The full-word write replaces the whole word. The ratio-only write touches just the two ratio fields, so the source choice and all spare bits are kept without a read-modify-write sequence. New ratios are held in the control word and reach the running counters only at the next output tick, so no period is ever cut short. A change of source restarts both counters with the ratios written in the same access.

Top module: `tick_mux_divider`

## Requirements
- R1: A synchronous active-high reset clears the control word to 0 (source 0, both ratios 1), and `tick_out` is 0 in the cycle after reset is released.
- R2: Control bits 17:16 choose the source. Strobes on the three other `src_tick` lines have no effect on `tick_out`.
- R3: The post-divider ratio is control bits 5:4 plus one (1 to 4). With the pre-divider out of the path, one output tick appears for every (bits 5:4 + 1) strobes of the chosen source.
- R4: With source 3 chosen, the pre-divider ratio is control bits 12:8 plus one (1 to 32).
- R5: With sources 0, 1 or 2 chosen, the value of bits 12:8 has no effect on the output rate.
- R6: The pre-divider comes first in the chain. With source 3 chosen, one output tick appears for every (pre ratio x post ratio) strobes.
- R7: A ratio-only write (`ratio_we`=1, `cfg_we`=0) replaces control bits 12:8 and 5:4 from `wdata` and keeps every other bit. If both enables are high, the full-word write wins.
- R8: A full-word write stores all 32 bits of `wdata`, spare bits included, and `ctl_rdata` returns the stored word in the next cycle.
- R9: Changed ratios (from either write port) take effect only after the next output tick. That tick still uses the old ratios, and the ticks after it use the new ones.
- R10: A full-word write that changes bits 17:16 resets both counters and loads the ratios from that write at once. No tick appears in the cycle after the write. The first tick then needs a full new period of the new source.
- R11: `tick_out` is high for one cycle, in the cycle after the strobe that completes a period. It is never high unless the chosen source strobed in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One-cycle enable strobes of the four sources |
| cfg_we | input | 1 | Full-word write strobe for the control word |
| ratio_we | input | 1 | Write strobe that updates only the two ratio fields |
| wdata | input | 32 | Write data shared by both write strobes |
| ctl_rdata | output | 32 | Current control word |
| tick_out | output | 1 | Divided output tick |

## Verification
The hardest situations to reach are ratio writes that land partway through a period, and source changes that land in the same cycle as a strobe or a completing tick. Only exact cycle placement shows whether the old ratios finish the current period and the counters restart cleanly. The stimulus runs a cycle-level model of the control word and both counters beside the design. It mixes directed write timings with pseudo-random strobes on all four sources, including writes issued on the exact cycle a period completes. Every cycle's expected tick is queued and compared, so a period that is off by even one cycle is caught.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = $clog2(NUM_SRC);
    localparam int PRE_W    = 5;
    localparam int POST_W   = 2;
    localparam int CTL_W    = 32;
    localparam int PRE_SRC  = NUM_SRC - 1;

    typedef struct packed {
        logic [13:0]       spare_hi;
        logic [SEL_W-1:0]  src_sel;
        logic [2:0]        spare_mid;
        logic [PRE_W-1:0]  pre_ratio;
        logic [1:0]        spare_lo;
        logic [POST_W-1:0] post_ratio;
        logic [3:0]        spare_low;
    } ctl_word_t;

    localparam logic [CTL_W-1:0] RATIO_MASK = 32'h0000_1F30;

    function automatic ctl_word_t merge_ratios(input ctl_word_t cur, input ctl_word_t upd);
        ctl_word_t r;
        r            = cur;
        r.pre_ratio  = upd.pre_ratio;
        r.post_ratio = upd.post_ratio;
        return r;
    endfunction

    function automatic logic uses_pre(input logic [SEL_W-1:0] sel);
        return sel == SEL_W'(PRE_SRC);
    endfunction

endpackage

// File: rtl/tmd_ctl_reg.sv
module tmd_ctl_reg
    import tmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              ratio_we,
    input  ctl_word_t         wdata,
    output ctl_word_t         ctl_q,
    output logic              sel_change
);

    assign sel_change = cfg_we && (wdata.src_sel != ctl_q.src_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (cfg_we) begin
            ctl_q <= wdata;
        end else if (ratio_we) begin
            ctl_q <= merge_ratios(ctl_q, wdata);
        end
    end

endmodule

// File: rtl/tmd_src_pick.sv
module tmd_src_pick
    import tmd_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               strobe
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
    end

    assign strobe = |hit;

endmodule

// File: rtl/tmd_stage_cnt.sv
module tmd_stage_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         reload,
    input  logic [W-1:0] ratio_in,
    input  logic         bypass,
    input  logic         in_strobe,
    output logic         out_pulse
);

    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic         at_end;

    assign at_end    = (cnt == limit);
    assign out_pulse = in_strobe && (bypass || at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            limit <= '0;
        end else if (restart || reload) begin
            cnt   <= '0;
            limit <= ratio_in;
        end else if (in_strobe && !bypass) begin
            cnt <= at_end ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/tick_mux_divider.sv
module tick_mux_divider
    import tmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_tick,
    input  logic                cfg_we,
    input  logic                ratio_we,
    input  logic [CTL_W-1:0]    wdata,
    output logic [CTL_W-1:0]    ctl_rdata,
    output logic                tick_out
);

    ctl_word_t ctl_q;
    ctl_word_t wr_word;
    logic      sel_change;
    logic      sel_strobe;
    logic      pre_pulse;
    logic      post_pulse;
    logic      reload;
    logic      tick_q;
    logic [PRE_W-1:0]  pre_next;
    logic [POST_W-1:0] post_next;

    assign wr_word = ctl_word_t'(wdata);

    tmd_ctl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .ratio_we   (ratio_we),
        .wdata      (wr_word),
        .ctl_q      (ctl_q),
        .sel_change (sel_change)
    );

    tmd_src_pick u_pick (
        .src_tick (src_tick),
        .sel      (ctl_q.src_sel),
        .strobe   (sel_strobe)
    );

    assign reload    = post_pulse && !sel_change;
    assign pre_next  = sel_change ? wr_word.pre_ratio  : ctl_q.pre_ratio;
    assign post_next = sel_change ? wr_word.post_ratio : ctl_q.post_ratio;

    tmd_stage_cnt #(.W(PRE_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart   (sel_change),
        .reload    (reload),
        .ratio_in  (pre_next),
        .bypass    (!uses_pre(ctl_q.src_sel)),
        .in_strobe (sel_strobe),
        .out_pulse (pre_pulse)
    );

    tmd_stage_cnt #(.W(POST_W)) u_post (
        .clk       (clk),
        .rst       (rst),
        .restart   (sel_change),
        .reload    (reload),
        .ratio_in  (post_next),
        .bypass    (1'b0),
        .in_strobe (pre_pulse),
        .out_pulse (post_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= post_pulse && !sel_change;
        end
    end

    assign tick_out  = tick_q;
    assign ctl_rdata = ctl_q;

endmodule

// File: rtl/tmd_checker.sv
module tmd_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  src_tick,
    input logic        cfg_we,
    input logic        ratio_we,
    input logic [31:0] wdata,
    input logic [31:0] ctl_rdata,
    input logic        tick_out
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (ctl_rdata == 32'h0 && !tick_out))
        else $error("R1 reset state");

    p_full_write_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (ctl_rdata == $past(wdata)))
        else $error("R8 full write");

    p_ratio_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (ratio_we && !cfg_we) |=>
            ((ctl_rdata & ~32'h0000_1F30) == ($past(ctl_rdata) & ~32'h0000_1F30)) &&
            ((ctl_rdata &  32'h0000_1F30) == ($past(wdata)     &  32'h0000_1F30)))
        else $error("R7 ratio write");

    p_tick_needs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(src_tick[ctl_rdata[17:16]]))
        else $error("R11 tick without strobe");

    p_quiet_after_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (wdata[17:16] != ctl_rdata[17:16])) |=> !tick_out)
        else $error("R10 tick after source change");

endmodule

bind tick_mux_divider tmd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (src_tick),
    .cfg_we    (cfg_we),
    .ratio_we  (ratio_we),
    .wdata     (wdata),
    .ctl_rdata (ctl_rdata),
    .tick_out  (tick_out)
);

// File: tb/tb_tick_mux_divider.sv
`timescale 1ns/1ps
module tb_tick_mux_divider;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  src_tick;
    logic        cfg_we;
    logic        ratio_we;
    logic [31:0] wdata;
    logic [31:0] ctl_rdata;
    logic        tick_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_tick;
        string req;
    } item_t;

    item_t exp_q[$];

    logic [31:0] m_reg;
    logic [4:0]  m_ap, m_cp;
    logic [1:0]  m_aq, m_cq;

    always #2 clk = ~clk;

    tick_mux_divider dut (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .cfg_we    (cfg_we),
        .ratio_we  (ratio_we),
        .wdata     (wdata),
        .ctl_rdata (ctl_rdata),
        .tick_out  (tick_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(tick_out === it.exp_tick, it.req, {31'h0, tick_out}, {31'h0, it.exp_tick});
        end
    end

    task automatic step(input logic [3:0] s, input logic cw, input logic rw,
                        input logic [31:0] wd, input string req);
        logic [1:0] sel;
        logic       strobe, prep, e;
        item_t      it;
        @(negedge clk);
        check(ctl_rdata === m_reg, "R8/R7 readback", ctl_rdata, m_reg);
        src_tick = s; cfg_we = cw; ratio_we = rw; wdata = wd;
        sel    = m_reg[17:16];
        strobe = s[sel];
        if (cw && wd[17:16] != sel) begin
            e = 1'b0; m_cp = '0; m_cq = '0; m_ap = wd[12:8]; m_aq = wd[5:4];
        end else begin
            prep = strobe && (sel != 2'd3 || m_cp == m_ap);
            if (strobe && sel == 2'd3) m_cp = (m_cp == m_ap) ? 5'd0 : m_cp + 5'd1;
            e = prep && (m_cq == m_aq);
            if (prep) m_cq = (m_cq == m_aq) ? 2'd0 : m_cq + 2'd1;
            if (e) begin
                m_ap = m_reg[12:8]; m_aq = m_reg[5:4]; m_cp = '0; m_cq = '0;
            end
        end
        if (cw) m_reg = wd;
        else if (rw) m_reg = (m_reg & ~32'h0000_1F30) | (wd & 32'h0000_1F30);
        it.exp_tick = e;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic strobes(input int n, input logic [3:0] s, input string req);
        for (int i = 0; i < n; i++) begin
            step(s, 1'b0, 1'b0, 32'h0, req);
            step(4'h0, 1'b0, 1'b0, 32'h0, req);
        end
    endtask

    initial begin
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_tick = '0; cfg_we = 0; ratio_we = 0; wdata = '0;
        m_reg = '0; m_ap = '0; m_cp = '0; m_aq = '0; m_cq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ctl_rdata === 32'h0, "R1 reset word", ctl_rdata, 32'h0);
        check(tick_out === 1'b0, "R1 reset tick", {31'h0, tick_out}, 32'h0);

        // R2: source 0, divide by 1; other lines ignored
        strobes(4, 4'b0001, "R2 src0");
        strobes(4, 4'b1110, "R2 others ignored");
        step(4'b0001, 0, 0, 0, "R2"); step(4'b0001, 0, 0, 0, "R2");

        // R3: source 1, post ratio 4
        step(4'h0, 1, 0, 32'h0001_0030, "R3 cfg");
        strobes(10, 4'b0010, "R3 post div4");
        strobes(3, 4'b1101, "R3 ignore");

        // R5: source 2 with pre field set, post ratio 2
        step(4'h0, 1, 0, 32'h0002_0510, "R5 cfg");
        strobes(8, 4'b0100, "R5 pre bypassed");

        // R4/R6: source 3 pre 3, post 2 -> every 6
        step(4'h0, 1, 0, 32'h0003_0210, "R4 cfg");
        strobes(14, 4'b1000, "R6 cascade");
        step(4'h0, 1, 0, 32'hA5A7_E2DF, "R8 spare bits");
        strobes(4, 4'b1000, "R4 pre 3");

        // R7/R9: ratio-only write mid period keeps select and spare bits
        step(4'h0, 1, 0, 32'h0003_0010, "R9 cfg");
        strobes(3, 4'b1000, "R9 partial");
        step(4'h0, 0, 1, 32'hFFFF_E3EF, "R7 ratio write");
        strobes(12, 4'b1000, "R9 shadow");
        step(4'b1000, 1, 1, 32'h0003_0000, "R7 priority");
        strobes(3, 4'b1000, "R9");

        // R10: source change mid count and on a strobe
        step(4'h0, 1, 0, 32'h0000_0020, "R10 cfg");
        strobes(2, 4'b0001, "R10 partial");
        step(4'b0011, 1, 0, 32'h0001_0010, "R10 change on strobe");
        strobes(5, 4'b0010, "R10 new period");

        // R11 plus mixed random stimulus
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 37 == 5)       step(r[3:0], 1, 0, $urandom, "R10 random");
            else if (i % 23 == 7)  step(r[3:0], 0, 1, $urandom, "R9 random");
            else                   step(r[3:0], 0, 0, 32'h0, "R11 random");
        end
        step(4'h0, 0, 0, 0, "R11 tail");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule